// File: doc/BRIEF.md
# Consecutive Fault Alarm Filter

This block sits behind the limit comparators of a temperature monitor. Each finished conversion delivers one pulse on `conv_valid`, together with two fault bits. One bit says the over-limit window was violated and the other says the critical limit was crossed. For each fault kind the block keeps a run counter of back-to-back faulting conversions. A status flag is raised only when the run reaches a threshold. That threshold is four conversions when the queue-enable bit of the configuration byte is set, and one conversion otherwise. A single noisy sample therefore cannot trip an alarm while the queue is on.

The over-limit result drives `int_o` in one of two styles. In comparator style, `int_o` simply tracks the qualified over-limit state. In interrupt style, `int_o` latches when the qualified state begins and stays high until a register read is signalled. The critical result drives `crit_alarm_o`. While `shutdown` is high, both alarm pins are forced low and the run counters hold their values.

Top module: `fault_alarm_filter`

## Requirements
- R1: After reset `over_flag`, `crit_flag`, `int_o` and `crit_alarm_o` are 0 and both run counters are zero.
- R2: With queue-enable bit 4 of `cfg` at 0, one faulting conversion sets the matching flag on the clock edge that samples it.
- R3: With bit 4 of `cfg` at 1, a flag is set only on the 4th consecutive faulting conversion; after 1 to 3 such conversions it remains 0.
- R4: A sampled conversion without the fault clears that fault's counter and flag, so a fresh run of the full threshold is needed again.
- R5: Over-limit and critical-limit faults are counted separately; `crit_alarm_o` follows the qualified critical state, and a run of one fault kind never sets the other kind's flag.
- R6: Each counter saturates at the threshold; a fault that persists for any number of conversions keeps the flag set and never wraps.
- R7: With `int_mode`=0 (comparator style), `int_o` takes the qualified over-limit state at every conversion, and `reg_read` has no effect on it.
- R8: With `int_mode`=1 (interrupt style), `int_o` is set when the qualified over-limit state goes from 0 to 1. It stays set after the fault ends and is cleared by a `reg_read` pulse. A fault that continues after the read does not set it again.
- R9: While `shutdown` is 1, `int_o` and `crit_alarm_o` are 0 from the next edge. Conversions are ignored, and counters and flags keep their values, so a run resumes where it stopped.
- R10: Fault inputs are ignored in cycles where `conv_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle pulse per finished conversion |
| over_fault | input | 1 | Over-limit window fault of this conversion |
| crit_fault | input | 1 | Critical-limit fault of this conversion |
| cfg | input | CFG_W | Configuration byte; bit QEN_BIT (4) enables the queue |
| int_mode | input | 1 | 0 = comparator style, 1 = interrupt style for `int_o` |
| shutdown | input | 1 | Shutdown control |
| reg_read | input | 1 | One-cycle pulse per register read access |
| over_flag | output | 1 | Qualified over-limit status flag |
| crit_flag | output | 1 | Qualified critical-limit status flag |
| int_o | output | 1 | Over-limit alarm pin, active high |
| crit_alarm_o | output | 1 | Critical alarm pin, active high |

## Verification
Every result is registered once. A flag, `int_o` or `crit_alarm_o` therefore changes on the first rising edge that samples the `conv_valid`, `reg_read` or `shutdown` pulse causing the change, and not one cycle later. The bench drives every input on a falling edge and holds each pulse for exactly one cycle. It then samples the outputs on the next falling edge, half a period after the edge that should have updated them. Counts that have no port of their own, such as a frozen or restarted run, are checked by applying further conversions and observing on which one the flag rises.

// File: rtl/fault_alarm_filter.sv
module fault_alarm_filter #(
  parameter int QUEUE_DEPTH = 4,
  parameter int CFG_W       = 8,
  parameter int QEN_BIT     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_valid,
  input  logic             over_fault,
  input  logic             crit_fault,
  input  logic [CFG_W-1:0] cfg,
  input  logic             int_mode,
  input  logic             shutdown,
  input  logic             reg_read,
  output logic             over_flag,
  output logic             crit_flag,
  output logic             int_o,
  output logic             crit_alarm_o
);
  localparam int CW = $clog2(QUEUE_DEPTH + 1);

  logic [CW-1:0] thr;
  logic [CW-1:0] cnt [2];
  logic [1:0]    fault_in, qual_next, flag;
  logic          step, int_r, crit_r;

  assign thr      = cfg[QEN_BIT] ? CW'(QUEUE_DEPTH) : CW'(1);
  assign fault_in = {crit_fault, over_fault};
  assign step     = conv_valid & ~shutdown;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign qual_next[ch] = fault_in[ch] && (cnt[ch] >= thr - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[ch]  <= '0;
        flag[ch] <= 1'b0;
      end else if (step) begin
        if (fault_in[ch]) cnt[ch] <= (cnt[ch] >= thr) ? thr : cnt[ch] + CW'(1);
        else              cnt[ch] <= '0;
        flag[ch] <= qual_next[ch];
      end
    end

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[ch] <= CW'(QUEUE_DEPTH));
    p_pass_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step && !fault_in[ch] |=> !flag[ch] && cnt[ch] == '0);
    p_run_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[ch]) && $stable(cfg) |-> cnt[ch] == thr);
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> $stable(cnt[ch]) && $stable(flag[ch]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_r  <= 1'b0;
      crit_r <= 1'b0;
    end else if (shutdown) begin
      int_r  <= 1'b0;
      crit_r <= 1'b0;
    end else begin
      if (conv_valid) crit_r <= qual_next[1];
      if (int_mode) begin
        if (conv_valid && qual_next[0] && !flag[0]) int_r <= 1'b1;
        else if (reg_read)                          int_r <= 1'b0;
      end else if (conv_valid) begin
        int_r <= qual_next[0];
      end
    end
  end

  assign over_flag    = flag[0];
  assign crit_flag    = flag[1];
  assign int_o        = int_r;
  assign crit_alarm_o = crit_r;

  p_shutdown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !int_o && !crit_alarm_o);
  p_comp_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode && step |=> int_o == over_flag);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_mode && reg_read && !conv_valid && !shutdown |=> !int_o);
  p_crit_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> crit_alarm_o == crit_flag);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> $stable(over_flag) && $stable(crit_flag));
endmodule

// File: tb/fault_alarm_filter_tb_top.sv
module fault_alarm_filter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_valid = 0, over_fault = 0, crit_fault = 0, int_mode = 0, shutdown = 0, reg_read = 0;
  logic [7:0] cfg = 8'h00;
  logic over_flag, crit_flag, int_o, crit_alarm_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  fault_alarm_filter dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .over_fault(over_fault),
    .crit_fault(crit_fault), .cfg(cfg), .int_mode(int_mode), .shutdown(shutdown),
    .reg_read(reg_read), .over_flag(over_flag), .crit_flag(crit_flag),
    .int_o(int_o), .crit_alarm_o(crit_alarm_o));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic conv(input logic o, input logic c);
    over_fault = o; crit_fault = c; conv_valid = 1;
    @(negedge clk);
    conv_valid = 0; over_fault = 0; crit_fault = 0;
  endtask

  task automatic do_read();
    reg_read = 1;
    @(negedge clk);
    reg_read = 0;
  endtask

  task automatic t_reset();
    check("R1", "over_flag", over_flag, 0);
    check("R1", "crit_flag", crit_flag, 0);
    check("R1", "int_o", int_o, 0);
    check("R1", "crit_alarm_o", crit_alarm_o, 0);
  endtask

  task automatic t_no_queue();
    cfg = 8'h00;
    conv(1, 0); check("R2", "single fault sets", over_flag, 1);
    conv(0, 0); check("R4", "pass clears", over_flag, 0);
  endtask

  task automatic t_queue();
    cfg = 8'h10;
    for (int i = 1; i <= 3; i++) begin
      conv(1, 0); check("R3", "below run", over_flag, 0);
    end
    conv(1, 0); check("R3", "4th fault sets", over_flag, 1);
    conv(0, 0); check("R4", "pass clears", over_flag, 0);
    for (int i = 1; i <= 3; i++) conv(1, 0);
    check("R4", "run restarted", over_flag, 0);
    conv(0, 0);
  endtask

  task automatic t_idle();
    cfg = 8'h10;
    over_fault = 1; crit_fault = 1;
    repeat (10) @(negedge clk);
    over_fault = 0; crit_fault = 0;
    check("R10", "idle fault ignored", over_flag, 0);
    for (int i = 1; i <= 3; i++) conv(1, 1);
    check("R10", "idle not counted", over_flag, 0);
    conv(1, 1); check("R10", "run of 4 sets", over_flag, 1);
    conv(0, 0);
  endtask

  task automatic t_crit();
    cfg = 8'h00;
    conv(0, 1);
    check("R5", "crit_flag", crit_flag, 1);
    check("R5", "crit_alarm_o", crit_alarm_o, 1);
    check("R5", "over_flag untouched", over_flag, 0);
    conv(0, 0); check("R5", "crit_alarm clears", crit_alarm_o, 0);
    cfg = 8'h10;
    conv(1, 1); conv(1, 1); conv(1, 0); conv(1, 1);
    check("R5", "over run qualifies", over_flag, 1);
    check("R5", "crit run broken", crit_flag, 0);
    conv(0, 0);
  endtask

  task automatic t_sat();
    cfg = 8'h10;
    for (int i = 1; i <= 20; i++) begin
      conv(1, 1);
      if (i == 4 || i == 20) begin
        check("R6", "over held", over_flag, 1);
        check("R6", "crit held", crit_alarm_o, 1);
      end
    end
    conv(0, 0);
  endtask

  task automatic t_comp();
    cfg = 8'h00; int_mode = 0;
    conv(1, 0); check("R7", "int follows", int_o, 1);
    do_read(); check("R7", "read ignored", int_o, 1);
    conv(0, 0); check("R7", "int drops", int_o, 0);
  endtask

  task automatic t_intr();
    cfg = 8'h00; int_mode = 1;
    conv(1, 0); check("R8", "int set", int_o, 1);
    conv(0, 0); check("R8", "int latched", int_o, 1);
    do_read(); check("R8", "read clears", int_o, 0);
    conv(1, 0); check("R8", "new rise sets", int_o, 1);
    do_read(); check("R8", "read clears again", int_o, 0);
    conv(1, 0); check("R8", "persisting no reset", int_o, 0);
    conv(0, 0); int_mode = 0;
  endtask

  task automatic t_shut();
    cfg = 8'h00; int_mode = 0;
    conv(1, 1);
    shutdown = 1; @(negedge clk);
    check("R9", "int forced low", int_o, 0);
    check("R9", "crit alarm forced low", crit_alarm_o, 0);
    check("R9", "flag held", over_flag, 1);
    shutdown = 0; conv(0, 0);
    cfg = 8'h10;
    conv(1, 0); conv(1, 0);
    shutdown = 1;
    for (int i = 0; i < 3; i++) conv(1, 0);
    check("R9", "conversions ignored", over_flag, 0);
    shutdown = 0;
    conv(1, 0); check("R9", "run frozen at 2", over_flag, 0);
    conv(1, 0); check("R9", "run resumes", over_flag, 1);
    conv(0, 0);
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_queue();
    t_queue();
    t_idle();
    t_crit();
    t_sat();
    t_comp();
    t_intr();
    t_shut();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule